// File: doc/BRIEF.md
# Interval timer with compare interrupt

This block gives each processor a private cycle counter and a one-shot compare alarm behind a single register address. The counter starts at zero out of reset and climbs by one on every clock. It is either 32 or 64 bits wide, and software can never load it. A read of the register port returns the counter. A write to the same port loads a 32-bit compare value. When the low 32 bits of the counter equal that value, an interrupt request is raised.

The request is held in a sticky pending flag until software acknowledges it or writes a fresh compare value. A mask input gates the flag onto the interrupt output. A typical use is a periodic tick. The handler reads the counter, adds a period to the last deadline, and writes the result back. It must make sure the new deadline lies ahead of the counter. A deadline that is already behind is only reached after the low 32 bits wrap. Each instance runs on its own and shares no state with other instances.

Top module: `interval_timer_irq`

## Requirements
- R1: The counter is zero while reset is asserted. It then rises by exactly one on every clock, and no register write changes it.
- R2: A read returns the counter, zero-extended to the bus width. With a 32-bit counter, bits 63:32 of the read data are zero.
- R3: A write loads bits 31:0 of the write data into the compare register and ignores the upper bits. Reset clears the compare register to zero.
- R4: In the cycle where the counter's low 32 bits equal the compare register, the pending flag is set. With the mask clear, the interrupt output is high in the following cycle, when the read data shows the compare value plus one.
- R5: The pending flag is sticky. It stays set, with no further match, until it is acknowledged or a compare write occurs.
- R6: An acknowledge clears the pending flag, and so does a compare write. A compare write in the match cycle suppresses that match. A match in the same cycle as an acknowledge still sets the flag.
- R7: The mask input is registered. The interrupt output is the pending flag gated by the mask value sampled at the previous clock edge, so a masked match stays pending and shows up once the mask is cleared.
- R8: A match needs exact equality. A compare value behind the counter raises no interrupt until the low 32 bits wrap around.
- R9: During reset the interrupt output is low, the registered mask is set and the pending flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe: loads the compare register |
| reg_wdata_i | input | BUS_W | Write data; only bits 31:0 are used |
| reg_rdata_o | output | BUS_W | Current counter value, zero-extended |
| irq_mask_i | input | 1 | 1 masks the interrupt output |
| irq_ack_i | input | 1 | Clears the pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a write or an acknowledge that lands in the one cycle where the counter equals the compare value. Only that cycle shows which clear or set wins. The stimulus sets a deadline a few cycles ahead. It then uses the bench model's counter to pick the exact falling edge before the match, and drives the strobe in that cycle. The low-32-bit wraparound cannot be reached in the run length. Instead, a deadline just behind the counter is held for a long window, to show that no inequality match fires.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned CMP_W = 32;
  typedef logic [CMP_W-1:0] cmp_t;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output cmp_t             cnt_lo_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             started_q;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      started_q <= 1'b1;
    end
  end

  generate
    if (CNT_W > CMP_W) begin : g_wide
      assign cnt_lo_o = cnt_q[CMP_W-1:0];
    end else begin : g_narrow
      assign cnt_lo_o = cnt_q;
    end
  endgenerate

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> cnt_q == $past(cnt_q) + 1'b1); // R1
endmodule

// File: rtl/itmr_compare.sv
module itmr_compare
  import itmr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  cmp_t wdata_i,
  input  cmp_t cnt_lo_i,
  output logic match_o
);
  cmp_t cmp_q, cmp_d;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_i) cmp_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= '0;
    else         cmp_q <= cmp_d;
  end

  assign match_o = (cnt_lo_i == cmp_q);

  AST_CMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cmp_q == $past(wdata_i)); // R3
endmodule

// File: rtl/itmr_pending.sv
module itmr_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic wr_i,
  input  logic ack_i,
  input  logic mask_i,
  output logic irq_o
);
  logic pend_q, pend_d;
  logic mask_q;

  // priority: compare write > match > acknowledge
  always_comb begin
    pend_d = pend_q;
    if (wr_i)         pend_d = 1'b0;
    else if (match_i) pend_d = 1'b1;
    else if (ack_i)   pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_i;
    end
  end

  assign irq_o = pend_q & ~mask_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && !wr_i |=> pend_q); // R4
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i && !wr_i |=> pend_q); // R5
  AST_PEND_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !pend_q); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(mask_i)); // R7
endmodule

// File: rtl/interval_timer_irq.sv
module interval_timer_irq
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  output logic [BUS_W-1:0] reg_rdata_o,
  input  logic             irq_mask_i,
  input  logic             irq_ack_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt;
  cmp_t             cnt_lo;
  logic             match;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[BUS_W-1:CMP_W];

  itmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_o   (cnt),
    .cnt_lo_o(cnt_lo)
  );

  itmr_compare u_compare (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i[CMP_W-1:0]),
    .cnt_lo_i(cnt_lo),
    .match_o (match)
  );

  itmr_pending u_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .wr_i   (reg_wr_i),
    .ack_i  (irq_ack_i),
    .mask_i (irq_mask_i),
    .irq_o  (irq_o)
  );

  generate
    if (BUS_W > CNT_W) begin : g_zext
      assign reg_rdata_o = {{(BUS_W-CNT_W){1'b0}}, cnt};
    end else begin : g_full
      assign reg_rdata_o = cnt;
    end
  endgenerate

  AST_IRQ_RESET: assert property (@(posedge clk_i) !rst_ni |-> !irq_o); // R9
endmodule

// File: tb/interval_timer_irq_tb.sv
`timescale 1ns/1ps
module interval_timer_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [63:0] wdata;
  logic        mask;
  logic        ack;
  logic [63:0] rdata, rdata_n;
  logic        irq, irq_n;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // behavioural reference state
  logic [63:0] m_cnt;
  logic [31:0] m_cmp;
  bit          m_pend;
  bit          m_mask;

  always #2.5 clk = ~clk;

  interval_timer_irq #(.CNT_W(64), .BUS_W(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_mask_i(mask), .irq_ack_i(ack), .irq_o(irq));

  interval_timer_irq #(.CNT_W(32), .BUS_W(64)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_n), .irq_mask_i(mask), .irq_ack_i(ack), .irq_o(irq_n));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit hit;
    cycles++;
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_pend = 0; m_mask = 1;
    end else begin
      hit = (m_cnt[31:0] == m_cmp);
      if (wr)       m_pend = 0;
      else if (hit) m_pend = 1;
      else if (ack) m_pend = 0;
      if (wr) m_cmp = wdata[31:0];
      m_mask = mask;
      m_cnt  = m_cnt + 1;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      chk(rdata, m_cnt, "R1/R2 wide read");
      chk(rdata_n, {32'h0, m_cnt[31:0]}, "R2 narrow read");
      chk({63'b0, irq}, {63'b0, m_pend & ~m_mask}, "R4-R7 wide irq");
      chk({63'b0, irq_n}, {63'b0, m_pend & ~m_mask}, "R4-R7 narrow irq");
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cmp(input logic [63:0] v);
    wr = 1'b1; wdata = v;
    tick();
    wr = 1'b0; wdata = 64'h0;
  endtask

  initial begin
    logic [63:0] r0;
    logic [31:0] tgt;
    int          waited;
    rst_n = 1'b0; wr = 1'b0; wdata = '0; mask = 1'b1; ack = 1'b0;
    tick(5);
    chk(rdata, 64'h0, "R1 counter held in reset");
    chk({63'b0, irq}, 64'h0, "R9 irq low in reset");
    chk(rdata_n, 64'h0, "R9 narrow counter in reset");
    rst_n = 1'b1;
    tick(3);
    r0 = rdata; tick();
    chk(rdata, r0 + 1, "R1 increments by one");
    // reset compare of zero matched at count 0 but mask is still set
    chk({63'b0, irq}, 64'h0, "R7/R9 masked after reset");
    mask = 1'b0; tick();
    chk({63'b0, irq}, 64'h1, "R5/R7 pending from zero match shows after unmask");
    ack = 1'b1; tick(); ack = 1'b0;
    chk({63'b0, irq}, 64'h0, "R6 acknowledge clears");

    // basic match with junk in upper write bits
    tgt = m_cnt[31:0] + 12;
    r0 = rdata;
    write_cmp({32'hDEADBEEF, tgt});
    chk(rdata, r0 + 1, "R1 write does not touch counter");
    waited = 0;
    while (!irq && waited < 100) begin tick(); waited++; end
    chk({32'h0, rdata[31:0]}, {32'h0, tgt + 32'd1}, "R3/R4 irq rises one after match");
    tick(10);
    chk({63'b0, irq}, 64'h1, "R5 pending sticky");
    write_cmp({32'h0, m_cnt[31:0] + 32'd1000});
    chk({63'b0, irq}, 64'h0, "R6 compare write clears");

    // masked match stays pending
    mask = 1'b1;
    write_cmp({32'h0, m_cnt[31:0] + 32'd8});
    tick(20);
    chk({63'b0, irq}, 64'h0, "R7 masked match hidden");
    mask = 1'b0; tick();
    chk({63'b0, irq}, 64'h1, "R7 pending appears on unmask");
    ack = 1'b1; tick(); ack = 1'b0;

    // deadline already behind
    write_cmp({32'h0, m_cnt[31:0] - 32'd5});
    tick(200);
    chk({63'b0, irq}, 64'h0, "R8 past deadline never fires");

    // write in the exact match cycle
    tgt = m_cnt[31:0] + 15;
    write_cmp({32'h0, tgt});
    while (m_cnt[31:0] != tgt) tick();
    write_cmp({32'h0, m_cnt[31:0] + 32'd5000});
    chk({63'b0, irq}, 64'h0, "R6 write beats match");
    tick(5);
    chk({63'b0, irq}, 64'h0, "R6 suppressed match stays clear");

    // acknowledge in the exact match cycle
    tgt = m_cnt[31:0] + 15;
    write_cmp({32'h0, tgt});
    while (m_cnt[31:0] != tgt) tick();
    ack = 1'b1; tick(); ack = 1'b0;
    chk({63'b0, irq}, 64'h1, "R6 match beats acknowledge");
    chk(rdata_n[63:32], 64'h0, "R2 narrow upper bits zero");
    tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule